// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a core that uses sliding register windows. Software always addresses 32 architectural registers. The eight low indices are globals, shared by every window. The other 24 indices reach into a larger physical array through a current window pointer. A second bank of eight globals can take the place of the normal bank under a control input. Each window owns eight private locals. Its outs are the same storage as the ins of the next window up, so a caller's arguments appear in the callee's ins after a save, without any copy.

The block has two combinational read ports and one synchronous write port. It also takes save and restore commands. A save moves the window pointer up by one and a restore moves it down by one, both modulo the window count. Each move is allowed only when the matching availability counter is non-zero. When that counter is zero, the block leaves everything as it is and raises a one-cycle overflow or underflow flag. The trap machinery in the core then handles the spill or fill.

Top module: `wrf_top`

## Requirements
- R1: After reset the window pointer is 0, the save-availability counter is NWIN-2, the restore-availability and other-windows counters are 0, both flags are low, and every register reads as zero.
- R2: Architectural index 0 always reads as zero, under either global bank, and a write to index 0 changes no register.
- R3: Indices 8-15 are the outs, 16-23 the locals and 24-31 the ins. The out with slot k in window N is the same storage as the in with slot k in window (N+1) mod NWIN.
- R4: A save when the save-availability counter is non-zero sets the window pointer to (pointer+1) mod NWIN. It also lowers the save-availability counter by one and raises the restore-availability counter by one. These changes are visible in the next cycle.
- R5: A restore when the restore-availability counter is non-zero sets the window pointer to (pointer-1) mod NWIN. It also raises the save-availability counter by one and lowers the restore-availability counter by one.
- R6: A save when the save-availability counter is zero leaves the pointer, the counters and all registers unchanged, and raises the overflow flag for exactly the next cycle.
- R7: A restore when the restore-availability counter is zero leaves the pointer, the counters and all registers unchanged, and raises the underflow flag for exactly the next cycle.
- R8: The sum of the save-availability, restore-availability and other-windows counters is NWIN-2 in every cycle.
- R9: With the bank-select input at 1, indices 1-7 reach the alternate globals, and at 0 they reach the normal globals. A write reaches only the bank that is selected.
- R10: The locals of a window are private to it. Writing a local in one window does not change the same local index in any other window.
- R11: When save and restore come in the same cycle, the save is acted on and the restore has no effect.
- R12: Reads are combinational on the current state. A write made in the same cycle as a save or restore goes to the window that was current before the move, and it is readable from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_glob_sel | input | 1 | 1 selects the alternate global bank |
| rd_a_idx | input | 5 | Read port A architectural index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 5 | Read port B architectural index |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write architectural index |
| wr_data | input | DATA_W | Write data |
| save_req | input | 1 | Save command, move up one window |
| restore_req | input | 1 | Restore command, move down one window |
| cwp_o | output | log2(NWIN) | Current window pointer |
| cansave_o | output | log2(NWIN) | Save-availability counter |
| canrestore_o | output | log2(NWIN) | Restore-availability counter |
| otherwin_o | output | log2(NWIN) | Other-windows counter |
| ovf_o | output | 1 | One-cycle window overflow flag |
| unf_o | output | 1 | One-cycle window underflow flag |

## Verification
Two things can fall in the same cycle: a register write and a window move. The move can also be a save and a restore together. The bench provokes both cases with directed steps and with random stimulus, where writes, saves and restores are drawn independently each cycle. It judges them with a reference model that applies the write through the pointer of that cycle before it moves the pointer. A read in the next cycle then tells whether the data landed in the old window or the new one. The same model settles a combined save and restore by acting on the save alone. The counters are then compared with the values that the model expects.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    typedef enum logic [1:0] {
        GRP_GLOB  = 2'd0,
        GRP_OUT   = 2'd1,
        GRP_LOCAL = 2'd2,
        GRP_IN    = 2'd3
    } reg_grp_e;

    localparam int ARCH_IDX_W   = 5;
    localparam int GLOB_COUNT   = 8;
    localparam int WIN_SLOTS    = 16;
    localparam int GLOB_REGION  = 2 * GLOB_COUNT;

    function automatic reg_grp_e grp_of(input logic [ARCH_IDX_W-1:0] idx);
        return reg_grp_e'(idx[4:3]);
    endfunction

endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int PW    = $clog2(NWIN),
    localparam int DEPTH = GLOB_REGION + NWIN * WIN_SLOTS,
    localparam int PHW   = $clog2(DEPTH)
) (
    input  logic [ARCH_IDX_W-1:0] arch_idx,
    input  logic [PW-1:0]         cwp,
    input  logic                  alt_sel,
    output logic [PHW-1:0]        phys_idx
);

    int win_sel;
    int slot_sel;

    always_comb begin
        win_sel  = 0;
        slot_sel = 0;
        phys_idx = '0;
        unique case (grp_of(arch_idx))
            GRP_GLOB: begin
                phys_idx = PHW'((alt_sel ? GLOB_COUNT : 0) + int'(arch_idx[2:0]));
            end
            GRP_OUT: begin
                win_sel  = (int'(cwp) + 1) % NWIN;
                slot_sel = 8 + int'(arch_idx[2:0]);
                phys_idx = PHW'(GLOB_REGION + win_sel * WIN_SLOTS + slot_sel);
            end
            GRP_LOCAL: begin
                win_sel  = int'(cwp);
                slot_sel = int'(arch_idx[2:0]);
                phys_idx = PHW'(GLOB_REGION + win_sel * WIN_SLOTS + slot_sel);
            end
            GRP_IN: begin
                win_sel  = int'(cwp);
                slot_sel = 8 + int'(arch_idx[2:0]);
                phys_idx = PHW'(GLOB_REGION + win_sel * WIN_SLOTS + slot_sel);
            end
            default: phys_idx = '0;
        endcase
    end

endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
    parameter int DEPTH  = 144,
    parameter int DATA_W = 32,
    parameter int ZERO_A = 0,
    parameter int ZERO_B = 8,
    localparam int PHW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHW-1:0]    rd_a_phys,
    output logic [DATA_W-1:0] rd_a_word,
    input  logic [PHW-1:0]    rd_b_phys,
    output logic [DATA_W-1:0] rd_b_word,
    input  logic              wr_go,
    input  logic [PHW-1:0]    wr_phys,
    input  logic [DATA_W-1:0] wr_word
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_go) begin
            mem_d[wr_phys] = wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_a_word = mem_q[rd_a_phys];
    assign rd_b_word = mem_q[rd_b_phys];

    // R2: the storage behind index 0 of both global banks is never written
    a_r2_zero_slots_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_q[ZERO_A] == '0) && (mem_q[ZERO_B] == '0));

endmodule

// File: rtl/wrf_win_ctrl.sv
module wrf_win_ctrl #(
    parameter int NWIN = 8,
    localparam int PW  = $clog2(NWIN),
    localparam int CW  = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_req,
    input  logic          restore_req,
    output logic [PW-1:0] cwp,
    output logic [CW-1:0] cansave,
    output logic [CW-1:0] canrestore,
    output logic [CW-1:0] otherwin,
    output logic          ovf,
    output logic          unf
);

    typedef struct packed {
        logic [PW-1:0] cwp;
        logic [CW-1:0] cansave;
        logic [CW-1:0] canrestore;
        logic [CW-1:0] otherwin;
        logic          ovf;
        logic          unf;
    } win_state_t;

    localparam logic [CW-1:0] SAVE_INIT = CW'(NWIN - 2);

    win_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        if (save_req) begin
            if (st_q.cansave == '0) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.cwp        = st_q.cwp + PW'(1);
                st_d.cansave    = st_q.cansave - CW'(1);
                st_d.canrestore = st_q.canrestore + CW'(1);
            end
        end else if (restore_req) begin
            if (st_q.canrestore == '0) begin
                st_d.unf = 1'b1;
            end else begin
                st_d.cwp        = st_q.cwp - PW'(1);
                st_d.cansave    = st_q.cansave + CW'(1);
                st_d.canrestore = st_q.canrestore - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cwp: '0, cansave: SAVE_INIT, canrestore: '0,
                      otherwin: '0, ovf: 1'b0, unf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cwp        = st_q.cwp;
    assign cansave    = st_q.cansave;
    assign canrestore = st_q.canrestore;
    assign otherwin   = st_q.otherwin;
    assign ovf        = st_q.ovf;
    assign unf        = st_q.unf;

    a_r4_save_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && cansave != '0) |=>
            (cwp == $past(cwp) + PW'(1)) && (cansave == $past(cansave) - CW'(1)) && !ovf);

    a_r5_restore_retreats: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && canrestore != '0) |=>
            (cwp == $past(cwp) - PW'(1)) && (canrestore == $past(canrestore) - CW'(1)) && !unf);

    a_r6_overflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && cansave == '0) |=> ovf && $stable(cwp) && $stable(cansave) && $stable(canrestore));

    a_r7_underflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && canrestore == '0) |=>
            unf && $stable(cwp) && $stable(cansave) && $stable(canrestore));

    a_r8_counter_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cansave) + int'(canrestore) + int'(otherwin)) == NWIN - 2);

    a_r11_save_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req && cansave != '0) |=> canrestore == $past(canrestore) + CW'(1));

    a_r6_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

endmodule

// File: rtl/wrf_top.sv
module wrf_top
    import wrf_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int DATA_W = 32,
    localparam int PW    = $clog2(NWIN),
    localparam int DEPTH = GLOB_REGION + NWIN * WIN_SLOTS,
    localparam int PHW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alt_glob_sel,
    input  logic [ARCH_IDX_W-1:0] rd_a_idx,
    output logic [DATA_W-1:0]     rd_a_data,
    input  logic [ARCH_IDX_W-1:0] rd_b_idx,
    output logic [DATA_W-1:0]     rd_b_data,
    input  logic                  wr_en,
    input  logic [ARCH_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  save_req,
    input  logic                  restore_req,
    output logic [PW-1:0]         cwp_o,
    output logic [PW-1:0]         cansave_o,
    output logic [PW-1:0]         canrestore_o,
    output logic [PW-1:0]         otherwin_o,
    output logic                  ovf_o,
    output logic                  unf_o
);

    localparam int NPORT = 3;

    logic [ARCH_IDX_W-1:0] port_idx  [NPORT];
    logic [PHW-1:0]        port_phys [NPORT];
    logic [DATA_W-1:0]     word_a, word_b;
    logic                  wr_go;

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign port_idx[2] = wr_idx;

    wrf_win_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .cwp         (cwp_o),
        .cansave     (cansave_o),
        .canrestore  (canrestore_o),
        .otherwin    (otherwin_o),
        .ovf         (ovf_o),
        .unf         (unf_o)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wrf_addr_map #(.NWIN(NWIN)) u_map (
            .arch_idx (port_idx[p]),
            .cwp      (cwp_o),
            .alt_sel  (alt_glob_sel),
            .phys_idx (port_phys[p])
        );
    end

    assign wr_go = wr_en && (wr_idx != '0);

    wrf_storage #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .ZERO_A (0),
        .ZERO_B (GLOB_COUNT)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_phys (port_phys[0]),
        .rd_a_word (word_a),
        .rd_b_phys (port_phys[1]),
        .rd_b_word (word_b),
        .wr_go     (wr_go),
        .wr_phys   (port_phys[2]),
        .wr_word   (wr_data)
    );

    assign rd_a_data = (rd_a_idx == '0) ? '0 : word_a;
    assign rd_b_data = (rd_b_idx == '0) ? '0 : word_b;

    // R12: a value written is readable at the same index next cycle if no window move happened
    a_r12_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0 && !save_req && !restore_req && rd_a_idx == wr_idx) |=>
            ($stable(rd_a_idx) && $stable(alt_glob_sel)) -> (rd_a_data == $past(wr_data)));

endmodule

// File: tb/wrf_top_bench.sv
`timescale 1ns/1ps
module wrf_top_bench;

    localparam int NWIN = 8;
    localparam int DW   = 32;
    localparam int PW   = $clog2(NWIN);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alt_glob_sel = 1'b0;
    logic [4:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic [PW-1:0] cwp_o, cansave_o, canrestore_o, otherwin_o;
    logic          ovf_o, unf_o;

    always #2.5 clk = ~clk;

    wrf_top #(.NWIN(NWIN), .DATA_W(DW)) u_wrf_top (
        .clk(clk), .rst_n(rst_n), .alt_glob_sel(alt_glob_sel),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .cwp_o(cwp_o), .cansave_o(cansave_o), .canrestore_o(canrestore_o),
        .otherwin_o(otherwin_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model, built from the requirements
    logic [DW-1:0] m_glob [2][8];
    logic [DW-1:0] m_win  [NWIN][16];
    int m_cwp, m_sv, m_rs;
    bit m_ovf, m_unf;

    function automatic logic [DW-1:0] mread(input logic [4:0] idx, input bit alt);
        int k = int'(idx[2:0]);
        if (idx == 0) return '0;
        case (idx[4:3])
            2'd0: return m_glob[alt][k];
            2'd1: return m_win[(m_cwp + 1) % NWIN][8 + k];
            2'd2: return m_win[m_cwp][k];
            default: return m_win[m_cwp][8 + k];
        endcase
    endfunction

    task automatic mwrite(input logic [4:0] idx, input bit alt, input logic [DW-1:0] v);
        int k = int'(idx[2:0]);
        if (idx == 0) return;
        case (idx[4:3])
            2'd0: m_glob[alt][k] = v;
            2'd1: m_win[(m_cwp + 1) % NWIN][8 + k] = v;
            2'd2: m_win[m_cwp][k] = v;
            default: m_win[m_cwp][8 + k] = v;
        endcase
    endtask

    task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit wr, input logic [4:0] widx, input logic [DW-1:0] wd,
                        input bit sv, input bit rs, input bit alt,
                        input logic [4:0] ra, input logic [4:0] rb, input string tag);
        @(negedge clk);
        wr_en = wr; wr_idx = widx; wr_data = wd;
        save_req = sv; restore_req = rs; alt_glob_sel = alt;
        rd_a_idx = ra; rd_b_idx = rb;
        #1;
        chk(tag, "read A", rd_a_data, mread(ra, alt));
        chk(tag, "read B", rd_b_data, mread(rb, alt));
        chk("R4", "cwp", DW'(cwp_o), DW'(m_cwp));
        chk("R5", "cansave", DW'(cansave_o), DW'(m_sv));
        chk("R5", "canrestore", DW'(canrestore_o), DW'(m_rs));
        chk("R8", "sum", DW'(int'(cansave_o) + int'(canrestore_o) + int'(otherwin_o)), DW'(NWIN - 2));
        chk("R6", "ovf", DW'(ovf_o), DW'(m_ovf));
        chk("R7", "unf", DW'(unf_o), DW'(m_unf));
        // R12: the write uses the pointer before any move
        if (wr) mwrite(widx, alt, wd);
        m_ovf = 0; m_unf = 0;
        if (sv) begin
            if (m_sv == 0) m_ovf = 1;
            else begin m_cwp = (m_cwp + 1) % NWIN; m_sv--; m_rs++; end
        end else if (rs) begin
            if (m_rs == 0) m_unf = 1;
            else begin m_cwp = (m_cwp + NWIN - 1) % NWIN; m_sv++; m_rs--; end
        end
    endtask

    task automatic idle_read(input bit alt, input logic [4:0] ra, input logic [4:0] rb,
                             input string tag);
        step(0, 0, 0, 0, 0, alt, ra, rb, tag);
    endtask

    initial begin
        #(5ns * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < 2; a++) for (int i = 0; i < 8; i++) m_glob[a][i] = '0;
        for (int w = 0; w < NWIN; w++) for (int i = 0; i < 16; i++) m_win[w][i] = '0;
        m_cwp = 0; m_sv = NWIN - 2; m_rs = 0; m_ovf = 0; m_unf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        idle_read(0, 5'd5, 5'd20, "R1");
        idle_read(1, 5'd3, 5'd31, "R1");

        // R2: index 0 write is discarded, reads zero
        step(1, 5'd0, 32'hDEAD_BEEF, 0, 0, 0, 5'd0, 5'd0, "R2");
        step(1, 5'd0, 32'h1234_5678, 0, 0, 1, 5'd0, 5'd0, "R2");
        idle_read(0, 5'd0, 5'd1, "R2");
        idle_read(1, 5'd0, 5'd1, "R2");

        // R9: banks separated
        step(1, 5'd3, 32'hA1A1_0003, 0, 0, 1, 5'd3, 5'd3, "R9");
        step(1, 5'd3, 32'hB2B2_0003, 0, 0, 0, 5'd3, 5'd3, "R9");
        idle_read(1, 5'd3, 5'd2, "R9");
        idle_read(0, 5'd3, 5'd2, "R9");

        // R3: out slot 2 becomes in slot 2 after a save
        step(1, 5'd10, 32'hC0C0_0010, 0, 0, 0, 5'd10, 5'd26, "R3");
        step(0, 0, 0, 1, 0, 0, 5'd10, 5'd26, "R3");
        idle_read(0, 5'd26, 5'd10, "R3");

        // R10: locals private
        step(1, 5'd17, 32'h1111_0017, 0, 0, 0, 5'd17, 5'd17, "R10");
        step(0, 0, 0, 1, 0, 0, 5'd17, 5'd17, "R10");
        step(1, 5'd17, 32'h2222_0017, 0, 0, 0, 5'd17, 5'd17, "R10");
        step(0, 0, 0, 0, 1, 0, 5'd17, 5'd17, "R10");
        idle_read(0, 5'd17, 5'd26, "R10");

        // R12: write in the same cycle as a save lands in the old window
        step(1, 5'd20, 32'h5A5A_0020, 1, 0, 0, 5'd20, 5'd20, "R12");
        idle_read(0, 5'd20, 5'd20, "R12");
        step(0, 0, 0, 0, 1, 0, 5'd20, 5'd20, "R12");
        idle_read(0, 5'd20, 5'd20, "R12");

        // R11: save and restore together
        step(0, 0, 0, 1, 1, 0, 5'd8, 5'd24, "R11");
        idle_read(0, 5'd8, 5'd24, "R11");

        // R4 and R6: save until overflow, then once more
        for (int i = 0; i < NWIN; i++) step(0, 0, 0, 1, 0, 0, 5'd9, 5'd25, "R6");
        idle_read(0, 5'd9, 5'd25, "R6");

        // R5 and R7: restore until underflow
        for (int i = 0; i < NWIN; i++) step(0, 0, 0, 0, 1, 0, 5'd9, 5'd25, "R7");
        idle_read(0, 5'd9, 5'd25, "R7");

        // random mix, all requirements checked by the model
        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 2) == 0, 5'($urandom), $urandom,
                 ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 5) == 0,
                 5'($urandom), 5'($urandom), "R12");
        end
        idle_read(0, 5'd1, 5'd30, "R3");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule